// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. A holding stage accepts a character while the shift stage is still sending the previous one. As a result, a host that reloads the holding stage as soon as it is flagged empty gets back-to-back frames with no idle gap on the line.

All timing comes from one transmit clock that runs at sixteen times the bit rate. The character format is chosen by four control inputs:
- the word length, 5 to 8 bits;
- parity on or off;
- the parity sense, even or odd;
- a long-stop select, which gives two stop bits, or one and a half stop bits when the word length is 5.

The shift stage reads the format at the moment it takes a character, so the format controls can change during a frame without affecting it. Two flags report the state of the block. One says the holding stage may be reloaded. The other says the line has finished a whole character, including its stop time. The holding flag is also given as an active-low copy.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While `rst` is high, and on the first sample after it is released, `txd` is 1, `hold_empty` is 1, `shift_empty` is 1 and `hold_empty_n` is 0.
- R2: A frame is sent in this order: a low start bit, then the data bits least significant first, then the parity bit if parity is on, then the stop time at high level. Each bit except the stop time lasts 16 clocks.
- R3: `word_sel` sets the word length to 5 + `word_sel` bits (0→5, 3→8). Data bits above the chosen length do not appear on the line.
- R4: With `par_en` = 0 no parity bit is sent. With `par_en` = 1, setting `par_even` = 1 makes the number of ones in the data bits plus the parity bit even, and setting `par_even` = 0 makes it odd.
- R5: The stop time is 16 clocks when `long_stop` = 0. When `long_stop` = 1 it is 24 clocks for the 5-bit length and 32 clocks for any other length.
- R6: A `load` sampled at a clock edge makes `hold_empty` 0 after that edge. If the shift stage is idle, the character moves to it at the next edge: after that edge `hold_empty` is 1 again and `txd` is already driving the start bit.
- R7: `shift_empty` goes to 0 when a character moves to the shift stage. It returns to 1 one edge after the last stop clock, unless another character is waiting. In that case the next start bit follows at once and `shift_empty` stays 0.
- R8: `hold_empty_n` is always the complement of `hold_empty`.
- R9: The format used for a frame is the one present on `word_sel`, `par_en`, `par_even` and `long_stop` at the edge where the character moves to the shift stage. Changing these inputs later has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, 16 times the bit rate |
| rst | input | 1 | Master reset, active high, asynchronous |
| load | input | 1 | Strobe that writes `data` into the holding stage |
| data | input | 8 | Character to send |
| word_sel | input | 2 | Word length select, length = 5 + value |
| par_en | input | 1 | 1 adds a parity bit |
| par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| long_stop | input | 1 | 1 selects a longer stop time (1.5 bits at length 5, 2 bits otherwise) |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding stage may be reloaded |
| hold_empty_n | output | 1 | Active-low copy of `hold_empty` |
| shift_empty | output | 1 | Line has finished the last character, including its stop time |

## Verification
The load edge is edge k. `hold_empty` is due low after edge k. The start bit and the return of `hold_empty` are due after edge k+1. Bit b of the frame is due on the 16 samples that follow edge k+1+16b. `shift_empty` is due high one edge after the last stop clock. The bench samples every output on the falling edge and walks a cycle index from the transfer edge, so each expected value is compared in exactly the cycle it is due. Back-to-back frames are checked for a start bit in the sample right after the first frame's final stop clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_BITS = 2'd1,
      TX_STOP = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic [1:0] word_sel;
      logic       par_en;
      logic       par_even;
      logic       long_stop;
   } tx_fmt_t;

   // stop time in clocks: 1 bit, 1.5 bits at the shortest length, 2 bits otherwise
   function automatic int unsigned stop_clocks(input int unsigned ovs,
                                               input logic long_stop,
                                               input logic [1:0] word_sel);
      if (!long_stop)
         return ovs;
      else if (word_sel == 2'd0)
         return ovs + ovs / 2;
      else
         return 2 * ovs;
   endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              take,
   output logic [DATA_W-1:0] dout,
   output logic              full
);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         dout <= '0;
         full <= 1'b0;
      end else if (load) begin
         dout <= din;
         full <= 1'b1;
      end else if (take) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LEN_W  = $clog2(DATA_W + 3)
) (
   input  logic [DATA_W-1:0] data,
   input  tx_fmt_t           fmt,
   output logic [DATA_W+1:0] frame,
   output logic [LEN_W-1:0]  nbits
);

   localparam int unsigned MIN_LEN = DATA_W - 3;

   logic [LEN_W-1:0]  len;
   logic [DATA_W-1:0] masked;
   logic              par;

   assign len = LEN_W'(MIN_LEN) + LEN_W'(fmt.word_sel);

   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      assign masked[g] = (LEN_W'(g) < len) ? data[g] : 1'b0;
   end

   assign par   = (^masked) ^ ~fmt.par_even;
   assign nbits = LEN_W'(1) + len + LEN_W'(fmt.par_en);

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (LEN_W'(i) < len)
            frame[i+1] = masked[i];
      end
      if (fmt.par_en)
         frame[len+1] = par;
   end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  tx_fmt_t           fmt,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   output logic              take,
   output logic              txd,
   output logic              shift_empty
);

   localparam int unsigned CNT_W = $clog2(2 * OVS);
   localparam int unsigned LEN_W = $clog2(DATA_W + 3);

   tx_state_e         state;
   logic [DATA_W+1:0] sreg;
   logic [DATA_W+1:0] frame;
   logic [LEN_W-1:0]  nbits;
   logic [LEN_W-1:0]  left;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  stop_lat;
   logic [CNT_W-1:0]  stop_new;

   uart_tx_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_framer (
      .data  (hold_data),
      .fmt   (fmt),
      .frame (frame),
      .nbits (nbits)
   );

   assign stop_new = CNT_W'(stop_clocks(OVS, fmt.long_stop, fmt.word_sel) - 1);
   assign take     = hold_full && ((state == TX_IDLE) ||
                                   (state == TX_STOP && cnt == '0));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state       <= TX_IDLE;
         sreg        <= '1;
         left        <= '0;
         cnt         <= '0;
         stop_lat    <= '0;
         txd         <= 1'b1;
         shift_empty <= 1'b1;
      end else if (take) begin
         sreg        <= frame;
         txd         <= frame[0];
         left        <= nbits - LEN_W'(1);
         cnt         <= CNT_W'(OVS - 1);
         stop_lat    <= stop_new;
         state       <= TX_BITS;
         shift_empty <= 1'b0;
      end else begin
         case (state)
            TX_BITS: begin
               if (cnt != '0) begin
                  cnt <= cnt - CNT_W'(1);
               end else if (left != '0) begin
                  sreg <= {1'b1, sreg[DATA_W+1:1]};
                  txd  <= sreg[1];
                  left <= left - LEN_W'(1);
                  cnt  <= CNT_W'(OVS - 1);
               end else begin
                  txd   <= 1'b1;
                  cnt   <= stop_lat;
                  state <= TX_STOP;
               end
            end
            TX_STOP: begin
               if (cnt != '0) begin
                  cnt <= cnt - CNT_W'(1);
               end else begin
                  state       <= TX_IDLE;
                  shift_empty <= 1'b1;
               end
            end
            default: begin
               txd <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        word_sel,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              long_stop,
   output logic              txd,
   output logic              hold_empty,
   output logic              hold_empty_n,
   output logic              shift_empty
);

   if (DATA_W < 5) begin : g_bad_width
      $error("uart_tx_dbuf: DATA_W must be at least 5");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("uart_tx_dbuf: OVS must be even and at least 4");
   end

   tx_fmt_t           fmt;
   logic              full;
   logic              take;
   logic [DATA_W-1:0] held;

   assign fmt = '{word_sel: word_sel, par_en: par_en,
                  par_even: par_even, long_stop: long_stop};

   uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .din  (data),
      .take (take),
      .dout (held),
      .full (full)
   );

   uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
      .clk         (clk),
      .rst         (rst),
      .fmt         (fmt),
      .hold_full   (full),
      .hold_data   (held),
      .take        (take),
      .txd         (txd),
      .shift_empty (shift_empty)
   );

   assign hold_empty   = ~full;
   assign hold_empty_n = full;

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker (
   input logic clk,
   input logic rst,
   input logic load,
   input logic txd,
   input logic hold_empty,
   input logic shift_empty
);

   AST_LOAD_FILLS_HOLD: assert property (@(posedge clk) disable iff (rst)
      load |=> !hold_empty);  // R6

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
      shift_empty |-> txd);  // R2

   AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (rst)
      $fell(shift_empty) |-> !txd);  // R7

   AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
      (shift_empty && hold_empty) |=> shift_empty);  // R7

   AST_TRANSFER_FREES_HOLD: assert property (@(posedge clk) disable iff (rst)
      ($fell(shift_empty) && !$past(load)) |-> hold_empty);  // R6

endmodule

bind uart_tx_dbuf uart_tx_checker u_chk (
   .clk         (clk),
   .rst         (rst),
   .load        (load),
   .txd         (txd),
   .hold_empty  (hold_empty),
   .shift_empty (shift_empty)
);

// File: tb/sim_uart_tx_dbuf.sv
`timescale 1ns/1ps
module sim_uart_tx_dbuf;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load = 1'b0;
   logic [7:0] data = '0;
   logic [1:0] word_sel = '0;
   logic       par_en = 1'b0;
   logic       par_even = 1'b0;
   logic       long_stop = 1'b0;
   logic       txd, hold_empty, hold_empty_n, shift_empty;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   uart_tx_dbuf u0 (
      .clk(clk), .rst(rst), .load(load), .data(data),
      .word_sel(word_sel), .par_en(par_en), .par_even(par_even),
      .long_stop(long_stop), .txd(txd), .hold_empty(hold_empty),
      .hold_empty_n(hold_empty_n), .shift_empty(shift_empty)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int frame_clocks(input logic [1:0] ws, input logic pe, input logic ls);
      int n = 1 + 5 + ws + pe;
      int st = !ls ? 16 : (ws == 0 ? 24 : 32);
      return 16 * n + st;
   endfunction

   function automatic logic exp_bit(input int i, input logic [7:0] d, input logic [1:0] ws,
                                    input logic pe, input logic ev);
      int b = i / 16;
      int len = 5 + ws;
      logic p = 1'b0;
      for (int j = 0; j < len; j++) p ^= d[j];
      if (!ev) p = ~p;
      if (b == 0) return 1'b0;
      if (b <= len) return d[b-1];
      if (pe && b == len + 1) return p;
      return 1'b1;
   endfunction

   // called at the falling edge right after the transfer edge
   task automatic check_frame(input logic [7:0] d, input logic [1:0] ws, input logic pe,
                              input logic ev, input logic ls, input logic scramble);
      int t = frame_clocks(ws, pe, ls);
      for (int i = 0; i < t; i++) begin
         if (i == 0 && scramble) begin
            word_sel = 2'($urandom); par_en = 1'($urandom);
            par_even = 1'($urandom); long_stop = 1'($urandom);
         end
         chk(txd == exp_bit(i, d, ws, pe, ev), "R2/R3/R4/R5/R9 txd", txd, exp_bit(i, d, ws, pe, ev));
         chk(shift_empty == 1'b0, "R7 shift_empty busy", shift_empty, 0);
         chk(hold_empty_n == ~hold_empty, "R8 hold_empty_n", hold_empty_n, ~hold_empty);
         @(negedge clk);
      end
      chk(shift_empty == 1'b1, "R7 shift_empty after stop", shift_empty, 1);
      chk(txd == 1'b1, "R5 line idle after stop", txd, 1);
   endtask

   task automatic run_frame(input logic [7:0] d, input logic [1:0] ws, input logic pe,
                            input logic ev, input logic ls, input logic scramble);
      data = d; word_sel = ws; par_en = pe; par_even = ev; long_stop = ls;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      chk(hold_empty == 1'b0, "R6 hold low after load", hold_empty, 0);
      chk(shift_empty == 1'b1, "R6 shift idle before transfer", shift_empty, 1);
      @(negedge clk);
      chk(hold_empty == 1'b1, "R6 hold free after transfer", hold_empty, 1);
      check_frame(d, ws, pe, ev, ls, scramble);
   endtask

   task automatic run_pair(input logic [7:0] a, input logic [7:0] b, input logic [1:0] ws,
                           input logic pe, input logic ev, input logic ls);
      int ta = frame_clocks(ws, pe, ls);
      data = a; word_sel = ws; par_en = pe; par_even = ev; long_stop = ls;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      @(negedge clk);
      chk(txd == 1'b0, "R6 start bit of first", txd, 0);
      data = b; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      for (int i = 1; i < ta; i++) begin
         chk(hold_empty == 1'b0, "R6 second waits in hold", hold_empty, 0);
         chk(txd == exp_bit(i, a, ws, pe, ev), "R2 first frame txd", txd, exp_bit(i, a, ws, pe, ev));
         @(negedge clk);
      end
      chk(hold_empty == 1'b1, "R7 back-to-back transfer", hold_empty, 1);
      check_frame(b, ws, pe, ev, ls, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1854));
      repeat (3) @(negedge clk);
      chk(txd == 1'b1, "R1 txd in reset", txd, 1);
      chk(hold_empty == 1'b1, "R1 hold_empty in reset", hold_empty, 1);
      chk(shift_empty == 1'b1, "R1 shift_empty in reset", shift_empty, 1);
      chk(hold_empty_n == 1'b0, "R1 hold_empty_n in reset", hold_empty_n, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(txd == 1'b1 && hold_empty && shift_empty, "R1 after release", txd, 1);

      // directed corners
      run_frame(8'hE5, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);  // R5 1.5 stop, R3 high bits dropped
      run_frame(8'hA7, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0);  // R4 even, R5 two stops
      run_frame(8'h3C, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);  // R4 odd
      run_frame(8'hFF, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1);  // R9 scramble
      run_pair(8'h55, 8'hAA, 2'd3, 1'b1, 1'b0, 1'b0);  // R7
      run_pair(8'h1F, 8'h0E, 2'd0, 1'b0, 1'b0, 1'b1);  // R7 with 1.5 stop

      for (int n = 0; n < 30; n++) begin
         run_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom));
         repeat (int'($urandom_range(0, 3))) @(negedge clk);
      end
      for (int n = 0; n < 4; n++)
         run_pair(8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule